// File: doc/BRIEF.md
# Region-Based Interconnect Access Firewall

This block guards one target on an on-chip interconnect. Every request carries an initiator ID, a read/write flag, a 3-bit request-info code and an address. The block checks each request against up to eight regions that software programs. The request is accepted only when the highest-numbered region that covers the address allows three things: that initiator for that direction, and that request-info code. The accept and reject outputs are combinational in the request cycle, so the fabric can forward the request or return an in-band error at once.

A rejected request also has effects that can be seen out of band. The first violation since the last clear is held in an error log: the initiator, the direction, the info code and the address. Any later violation only sets a multiple-error flag. One of two sticky status bits is also set. The application bit is set when the request's debug bit is 0, and the debug bit is set when it is 1. An interrupt is raised while the log holds an entry and interrupts are enabled. Software uses a write-only register port to program the regions and the control bit, and to clear the log.

Top module: `fw_guard`

## Requirements
- R1: After reset, every region is disabled, all permissions are zero, the log is empty, both status bits and the multiple-error flag are 0, irq_o is 0, and every request is rejected.
- R2: While req_valid_i is high, exactly one of req_accept_o and req_error_o is high in the same cycle. req_accept_o is high only when the winning region has three things set: the bit indexed by req_info_i in its info mask, and the bit indexed by req_init_i in its read mask (for req_write_i=0) or in its write mask (for req_write_i=1). Both outputs are 0 while req_valid_i is low.
- R3: When several enabled regions cover the address, the highest-numbered region alone decides the outcome.
- R4: A region covers an address when it is enabled and the address agrees with its base in every bit above bit k. Here k is the 6-bit size exponent, the region is 2^k bytes, and k >= 32 covers all addresses. An address covered by no region is rejected.
- R5: The request-info code is {debug, type, supervisor} in bits [2:0], with debug in bit 2. Code c is allowed by a region when bit c of its 8-bit info mask is set.
- R6: One cycle after the first rejected request while the log is empty, log_valid_o is 1 and the log outputs hold that request's initiator, direction, info code and address.
- R7: A rejected request while the log holds an entry sets log_multi_o in the next cycle and leaves the captured fields unchanged.
- R8: A write to offset 0x10 empties the log and clears both status bits. A write to offset 0x18 clears log_multi_o. A violation in the same cycle as either clear is still recorded: it is captured into the freed log, or it sets the flag.
- R9: A rejected request sets err_dbg_o when its debug bit is 1 and err_app_o otherwise. Both bits stay set until the log is cleared.
- R10: irq_o equals control bit 0 (at offset 0x08) AND log_valid_o.
- R11: Region r uses offset 0x28 + 0x20*r for its info mask [7:0], +0x08 for its read mask [63:0], +0x10 for its write mask [63:0], and +0x18 for its match register. The match register holds size exponent [5:0], enable [6] and base [63:32].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_init_i | input | 6 | Initiator ID |
| req_info_i | input | 3 | Request-info code {debug,type,supervisor} |
| req_addr_i | input | 32 | Request address |
| req_accept_o | output | 1 | Request allowed through |
| req_error_o | output | 1 | Request rejected, in-band error |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 12 | Register byte offset |
| cfg_wdata_i | input | 64 | Register write data |
| irq_o | output | 1 | Violation interrupt |
| err_app_o | output | 1 | Sticky violation status, application mode |
| err_dbg_o | output | 1 | Sticky violation status, debug mode |
| log_valid_o | output | 1 | Log holds an entry |
| log_multi_o | output | 1 | Further violations after the captured one |
| log_init_o | output | 6 | Logged initiator |
| log_write_o | output | 1 | Logged direction |
| log_info_o | output | 3 | Logged info code |
| log_addr_o | output | 32 | Logged address |

## Verification
A software clear can land on the same clock edge as a new violation, and the two actions act on the same log and status state. The bench drives the single-clear write and a rejected debug-mode request in one cycle. It expects the log to be freed and then refilled with the new request, with only the debug status bit left set. It then holds a logged entry and drives a violation together with the multi-clear write, and it expects the multiple-error flag to be set in the next cycle.

// File: rtl/fw_pkg.sv
package fw_pkg;
  localparam int INFO_W     = 3;
  localparam int INFO_CODES = 1 << INFO_W;
  localparam int INFO_DBG   = 2;
  localparam int DW         = 64;

  localparam int OFF_CTRL   = 'h08;
  localparam int OFF_CLR_S  = 'h10;
  localparam int OFF_CLR_M  = 'h18;
  localparam int OFF_RGN0   = 'h28;
  localparam int RGN_STRIDE = 'h20;
  localparam int SUB_INFO   = 'h00;
  localparam int SUB_RD     = 'h08;
  localparam int SUB_WR     = 'h10;
  localparam int SUB_MATCH  = 'h18;

  localparam int M_SIZE_W   = 6;
  localparam int M_EN_BIT   = 6;
  localparam int M_BASE_LSB = 32;

  typedef struct packed {
    logic hit;
    logic ok;
  } verdict_t;
endpackage

// File: rtl/fw_cfg.sv
module fw_cfg
  import fw_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 32,
  parameter int NID  = 64,
  parameter int CAW  = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic [CAW-1:0]        cfg_addr_i,
  input  logic [DW-1:0]         cfg_wdata_i,
  output logic [INFO_CODES-1:0] info_perm_o [NREG],
  output logic [NID-1:0]        rd_perm_o   [NREG],
  output logic [NID-1:0]        wr_perm_o   [NREG],
  output logic [AW-1:0]         base_o      [NREG],
  output logic [M_SIZE_W-1:0]   size_o      [NREG],
  output logic [NREG-1:0]       en_o,
  output logic                  irq_en_o,
  output logic                  clr_single_o,
  output logic                  clr_multi_o
);
  int wa;
  assign wa = int'(cfg_addr_i);

  assign clr_single_o = cfg_we_i && (wa == OFF_CLR_S);
  assign clr_multi_o  = cfg_we_i && (wa == OFF_CLR_M);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_o <= 1'b0;
      en_o     <= '0;
      for (int r = 0; r < NREG; r++) begin
        info_perm_o[r] <= '0;
        rd_perm_o[r]   <= '0;
        wr_perm_o[r]   <= '0;
        base_o[r]      <= '0;
        size_o[r]      <= '0;
      end
    end else if (cfg_we_i) begin
      if (wa == OFF_CTRL) irq_en_o <= cfg_wdata_i[0];
      for (int r = 0; r < NREG; r++) begin
        if (wa == OFF_RGN0 + r*RGN_STRIDE + SUB_INFO)
          info_perm_o[r] <= cfg_wdata_i[INFO_CODES-1:0];
        if (wa == OFF_RGN0 + r*RGN_STRIDE + SUB_RD)
          rd_perm_o[r] <= cfg_wdata_i[NID-1:0];
        if (wa == OFF_RGN0 + r*RGN_STRIDE + SUB_WR)
          wr_perm_o[r] <= cfg_wdata_i[NID-1:0];
        if (wa == OFF_RGN0 + r*RGN_STRIDE + SUB_MATCH) begin
          size_o[r] <= cfg_wdata_i[M_SIZE_W-1:0];
          en_o[r]   <= cfg_wdata_i[M_EN_BIT];
          base_o[r] <= cfg_wdata_i[M_BASE_LSB +: AW];
        end
      end
    end
  end
endmodule

// File: rtl/fw_decide.sv
module fw_decide
  import fw_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 32,
  parameter int NID  = 64,
  parameter int IDW  = 6
) (
  input  logic                  req_write_i,
  input  logic [IDW-1:0]        req_init_i,
  input  logic [INFO_W-1:0]     req_info_i,
  input  logic [AW-1:0]         req_addr_i,
  input  logic [INFO_CODES-1:0] info_perm_i [NREG],
  input  logic [NID-1:0]        rd_perm_i   [NREG],
  input  logic [NID-1:0]        wr_perm_i   [NREG],
  input  logic [AW-1:0]         base_i      [NREG],
  input  logic [M_SIZE_W-1:0]   size_i      [NREG],
  input  logic [NREG-1:0]       en_i,
  output verdict_t              verdict_o
);
  logic [NREG-1:0] hit;
  logic [NREG-1:0] pass;

  for (genvar r = 0; r < NREG; r++) begin : g_rgn
    logic [AW-1:0] low_mask;
    assign low_mask = (int'(size_i[r]) >= AW) ? '1
                    : ((AW'(1) << size_i[r]) - AW'(1));
    assign hit[r]  = en_i[r] && (((req_addr_i ^ base_i[r]) & ~low_mask) == '0);
    assign pass[r] = info_perm_i[r][req_info_i] &&
                     (req_write_i ? wr_perm_i[r][req_init_i] : rd_perm_i[r][req_init_i]);
  end

  // highest-numbered hit wins
  always_comb begin
    verdict_o = '0;
    for (int r = 0; r < NREG; r++) begin
      if (hit[r]) begin
        verdict_o.hit = 1'b1;
        verdict_o.ok  = pass[r];
      end
    end
  end
endmodule

// File: rtl/fw_log.sv
module fw_log
  import fw_pkg::*;
#(
  parameter int AW  = 32,
  parameter int IDW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              viol_i,
  input  logic [IDW-1:0]    init_i,
  input  logic              write_i,
  input  logic [INFO_W-1:0] info_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              clr_single_i,
  input  logic              clr_multi_i,
  output logic              valid_o,
  output logic              multi_o,
  output logic [IDW-1:0]    init_o,
  output logic              write_o,
  output logic [INFO_W-1:0] info_o,
  output logic [AW-1:0]     addr_o,
  output logic              err_app_o,
  output logic              err_dbg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      multi_o   <= 1'b0;
      init_o    <= '0;
      write_o   <= 1'b0;
      info_o    <= '0;
      addr_o    <= '0;
      err_app_o <= 1'b0;
      err_dbg_o <= 1'b0;
    end else begin
      if (clr_single_i) begin
        valid_o   <= 1'b0;
        err_app_o <= 1'b0;
        err_dbg_o <= 1'b0;
      end
      if (clr_multi_i) multi_o <= 1'b0;
      // a violation outranks a clear issued in the same cycle
      if (viol_i) begin
        if (!valid_o || clr_single_i) begin
          valid_o <= 1'b1;
          init_o  <= init_i;
          write_o <= write_i;
          info_o  <= info_i;
          addr_o  <= addr_i;
        end else begin
          multi_o <= 1'b1;
        end
        if (info_i[INFO_DBG]) err_dbg_o <= 1'b1;
        else                  err_app_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fw_guard.sv
module fw_guard
  import fw_pkg::*;
#(
  parameter int NREG = 8,
  parameter int AW   = 32,
  parameter int IDW  = 6,
  parameter int CAW  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [IDW-1:0]    req_init_i,
  input  logic [INFO_W-1:0] req_info_i,
  input  logic [AW-1:0]     req_addr_i,
  output logic              req_accept_o,
  output logic              req_error_o,
  input  logic              cfg_we_i,
  input  logic [CAW-1:0]    cfg_addr_i,
  input  logic [DW-1:0]     cfg_wdata_i,
  output logic              irq_o,
  output logic              err_app_o,
  output logic              err_dbg_o,
  output logic              log_valid_o,
  output logic              log_multi_o,
  output logic [IDW-1:0]    log_init_o,
  output logic              log_write_o,
  output logic [INFO_W-1:0] log_info_o,
  output logic [AW-1:0]     log_addr_o
);
  localparam int NID = 1 << IDW;

  logic [INFO_CODES-1:0] info_perm [NREG];
  logic [NID-1:0]        rd_perm   [NREG];
  logic [NID-1:0]        wr_perm   [NREG];
  logic [AW-1:0]         base      [NREG];
  logic [M_SIZE_W-1:0]   size      [NREG];
  logic [NREG-1:0]       en;
  logic                  irq_en, clr_single, clr_multi;
  verdict_t              verdict;

  fw_cfg #(.NREG(NREG), .AW(AW), .NID(NID), .CAW(CAW)) u_cfg (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .info_perm_o(info_perm), .rd_perm_o(rd_perm), .wr_perm_o(wr_perm),
    .base_o(base), .size_o(size), .en_o(en), .irq_en_o(irq_en),
    .clr_single_o(clr_single), .clr_multi_o(clr_multi)
  );

  fw_decide #(.NREG(NREG), .AW(AW), .NID(NID), .IDW(IDW)) u_decide (
    .req_write_i, .req_init_i, .req_info_i, .req_addr_i,
    .info_perm_i(info_perm), .rd_perm_i(rd_perm), .wr_perm_i(wr_perm),
    .base_i(base), .size_i(size), .en_i(en), .verdict_o(verdict)
  );

  assign req_accept_o = req_valid_i &&  verdict.ok;
  assign req_error_o  = req_valid_i && !verdict.ok;

  fw_log #(.AW(AW), .IDW(IDW)) u_log (
    .clk_i, .rst_ni,
    .viol_i(req_error_o), .init_i(req_init_i), .write_i(req_write_i),
    .info_i(req_info_i), .addr_i(req_addr_i),
    .clr_single_i(clr_single), .clr_multi_i(clr_multi),
    .valid_o(log_valid_o), .multi_o(log_multi_o), .init_o(log_init_o),
    .write_o(log_write_o), .info_o(log_info_o), .addr_o(log_addr_o),
    .err_app_o, .err_dbg_o
  );

  assign irq_o = irq_en && log_valid_o;
endmodule

// File: rtl/fw_guard_chk.sv
module fw_guard_chk
  import fw_pkg::*;
#(
  parameter int AW  = 32,
  parameter int IDW = 6,
  parameter int CAW = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [INFO_W-1:0] req_info_i,
  input logic              req_accept_o,
  input logic              req_error_o,
  input logic              cfg_we_i,
  input logic [CAW-1:0]    cfg_addr_i,
  input logic              irq_o,
  input logic              err_app_o,
  input logic              err_dbg_o,
  input logic              log_valid_o,
  input logic              log_multi_o,
  input logic [IDW-1:0]    log_init_o,
  input logic [AW-1:0]     log_addr_o
);
  logic clr_s;
  assign clr_s = cfg_we_i && (cfg_addr_i == CAW'(OFF_CLR_S));

  assert_one_verdict_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> (req_accept_o != req_error_o));

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !(req_accept_o || req_error_o));

  assert_log_fills_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_error_o |=> log_valid_o);

  assert_multi_needs_entry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(log_multi_o) |-> $past(log_valid_o));

  assert_fields_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (log_valid_o && $past(log_valid_o) && !$past(clr_s))
      |-> ($stable(log_addr_o) && $stable(log_init_o)));

  assert_app_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_app_o) |-> $past(req_error_o && !req_info_i[INFO_DBG]));

  assert_dbg_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_dbg_o) |-> $past(req_error_o && req_info_i[INFO_DBG]));

  assert_irq_needs_log_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> log_valid_o);
endmodule

bind fw_guard fw_guard_chk #(.AW(AW), .IDW(IDW), .CAW(CAW)) u_chk (
  .clk_i, .rst_ni, .req_valid_i, .req_info_i, .req_accept_o, .req_error_o,
  .cfg_we_i, .cfg_addr_i, .irq_o, .err_app_o, .err_dbg_o,
  .log_valid_o, .log_multi_o, .log_init_o, .log_addr_o
);

// File: tb/fw_guard_tb.sv
module fw_guard_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [5:0]  req_init_i = '0;
  logic [2:0]  req_info_i = '0;
  logic [31:0] req_addr_i = '0;
  logic        req_accept_o, req_error_o;
  logic        cfg_we_i = 1'b0;
  logic [11:0] cfg_addr_i = '0;
  logic [63:0] cfg_wdata_i = '0;
  logic        irq_o, err_app_o, err_dbg_o, log_valid_o, log_multi_o, log_write_o;
  logic [5:0]  log_init_o;
  logic [2:0]  log_info_o;
  logic [31:0] log_addr_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [7:0]  b_info [8];
  logic [63:0] b_rd [8], b_wr [8];
  logic [31:0] b_base [8];
  int          b_k [8];
  bit          b_en [8];

  always #2.5 clk_i = ~clk_i;

  fw_guard u_dut (.*);

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(int a, logic [63:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = 12'(a); cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic set_region(int r, bit en, logic [31:0] base, int k,
                            logic [7:0] inf, logic [63:0] rd, logic [63:0] wr);
    int o = 'h28 + r*'h20;
    b_en[r] = en; b_base[r] = base; b_k[r] = k;
    b_info[r] = inf; b_rd[r] = rd; b_wr[r] = wr;
    cfg_wr(o,        {56'd0, inf});
    cfg_wr(o + 'h08, rd);
    cfg_wr(o + 'h10, wr);
    cfg_wr(o + 'h18, {base, 25'd0, en, 6'(k)});
  endtask

  function automatic bit exp_ok(int id, bit wr, int inf, logic [31:0] a);
    int w = -1;
    for (int r = 0; r < 8; r++)
      if (b_en[r] && ((a >> b_k[r]) == (b_base[r] >> b_k[r]))) w = r;
    if (w < 0) return 1'b0;
    return b_info[w][inf] && (wr ? b_wr[w][id] : b_rd[w][id]);
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] addrs [4];
    addrs = '{32'h0000_1004, 32'h0000_1810, 32'h0000_3000, 32'h0000_8008};
    for (int r = 0; r < 8; r++) begin
      b_en[r] = 0; b_info[r] = '0; b_rd[r] = '0; b_wr[r] = '0; b_base[r] = '0; b_k[r] = 0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 log_valid", log_valid_o, 0);
    chk("R1 multi", log_multi_o, 0);
    chk("R1 status", {err_app_o, err_dbg_o}, 0);
    chk("R1 irq", irq_o, 0);
    req_valid_i = 1'b1; req_addr_i = 32'h1004; req_info_i = 3'd0;
    #1;
    chk("R1 reject at reset", {req_accept_o, req_error_o}, 2'b01);
    req_valid_i = 1'b0;
    cfg_wr('h10, '0);

    // R11 region layout, R4 size/base
    set_region(0, 1, 32'h1000, 12, 8'hFF, '1, 64'h0000_0000_0000_00FF);
    set_region(1, 1, 32'h1800,  8, 8'h0A, 64'h5555_5555_5555_5555, '0);
    set_region(7, 1, 32'h8000,  4, 8'h01, 64'h8000_0000_0000_0000, '0);

    // sweep: R2 (0x1004), R3/R5 (0x1810 overlap), R4 (0x3000 miss), R11 (0x8008)
    for (int ai = 0; ai < 4; ai++)
      for (int id = 0; id < 64; id++)
        for (int wr = 0; wr < 2; wr++)
          for (int inf = 0; inf < 8; inf++) begin
            bit e;
            @(negedge clk_i);
            req_valid_i = 1'b1; req_addr_i = addrs[ai]; req_init_i = 6'(id);
            req_write_i = wr[0]; req_info_i = 3'(inf);
            e = exp_ok(id, wr[0], inf, addrs[ai]);
            #1;
            case (ai)
              0: chk("R2 verdict", {req_accept_o, req_error_o}, {e, !e});
              1: chk("R3 R5 verdict", {req_accept_o, req_error_o}, {e, !e});
              2: chk("R4 verdict", {req_accept_o, req_error_o}, {e, !e});
              default: chk("R11 verdict", {req_accept_o, req_error_o}, {e, !e});
            endcase
          end
    @(negedge clk_i);
    req_valid_i = 1'b0;
    #1;
    chk("R2 idle", {req_accept_o, req_error_o}, 0);
    // first violation: id 8 write info 0 at 0x1004
    chk("R6 valid", log_valid_o, 1);
    chk("R6 init", log_init_o, 8);
    chk("R6 write", log_write_o, 1);
    chk("R6 info", log_info_o, 0);
    chk("R6 addr", log_addr_o, 32'h1004);
    chk("R7 multi", log_multi_o, 1);
    chk("R9 app", err_app_o, 1);
    chk("R9 dbg", err_dbg_o, 1);
    chk("R10 irq disabled", irq_o, 0);
    cfg_wr('h08, 64'd1);
    #1;
    chk("R10 irq enabled", irq_o, 1);
    cfg_wr('h18, '0);
    #1;
    chk("R8 multi cleared", log_multi_o, 0);
    chk("R8 entry kept", log_valid_o, 1);
    cfg_wr('h10, '0);
    #1;
    chk("R8 log cleared", log_valid_o, 0);
    chk("R8 status cleared", {err_app_o, err_dbg_o}, 0);
    chk("R10 irq drops", irq_o, 0);

    // R8: violation coinciding with single clear, debug mode
    cfg_wr('h28 + 'h20*2 + 'h18, '0);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = 32'h0000_3000; req_init_i = 6'd5;
    req_write_i = 1'b0; req_info_i = 3'd5;
    cfg_we_i = 1'b1; cfg_addr_i = 12'h010;
    @(negedge clk_i);
    req_valid_i = 1'b0; cfg_we_i = 1'b0;
    #1;
    chk("R8 capture wins", log_valid_o, 1);
    chk("R8 new init", log_init_o, 5);
    chk("R8 new addr", log_addr_o, 32'h3000);
    chk("R9 debug only", {err_app_o, err_dbg_o}, 2'b01);
    chk("R7 multi stays 0", log_multi_o, 0);
    // R8: violation coinciding with multi clear
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = 32'h0000_3004; req_init_i = 6'd9; req_info_i = 3'd0;
    cfg_we_i = 1'b1; cfg_addr_i = 12'h018;
    @(negedge clk_i);
    req_valid_i = 1'b0; cfg_we_i = 1'b0;
    #1;
    chk("R8 flag set wins", log_multi_o, 1);
    chk("R7 fields kept", log_init_o, 5);
    chk("R9 app set", err_app_o, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule